// File: doc/BRIEF.md
# Sleep-Mode Entry and Exit Sequencer

This block controls entry into and exit from a low-power sleep state of a synchronous SRAM. The sleep request arrives asynchronously to the clock. It first passes through a two-stage synchronizer. The synchronized copy then drives a four-state machine with the states AWAKE, ENTERING, ASLEEP and EXITING. Entry takes a fixed number of cycles, and so does exit. Array contents are retained throughout, so the block never touches stored data. It only gates new work.

The transitions are named as follows:
- **start-entry** (AWAKE to ENTERING): the synchronized request is high.
- **entry-done** (ENTERING to ASLEEP): the entry count has run out. This happens whatever the request does meanwhile.
- **wake** (ASLEEP to EXITING): the synchronized request is low.
- **exit-done** (EXITING to AWAKE): the recovery count has run out.

In every state other than AWAKE, an access-inhibit output tells the SRAM control logic to refuse or cancel accesses. As a result, no array write is committed once entry has begun.

The block also keeps two sticky flags, both cleared only by reset:
- A violation flag records any access start seen while inhibited. This covers the entering, sleeping and recovery windows.
- An abort flag records that an access was in flight at the moment entry began. That access is reported as invalid.

Top module: `sleep_seq`

## Requirements
- R1: After reset, acc_inhibit, sleep_active, recov_viol and acc_aborted are all 0 and the block is AWAKE.
- R2: The request reaches the state machine through two flip-flop stages. If sleep_req_async rises between edges, acc_inhibit first reads 1 after the third rising edge that follows, and reads 0 after the first and second.
- R3: ENTERING lasts exactly ENTER_CYC (default 2) cycles, with acc_inhibit=1 and sleep_active=0. sleep_active then becomes 1.
- R4: sleep_active is 1 only in ASLEEP, and it stays 1 while the synchronized request remains high.
- R5: Once the synchronized request is low in ASLEEP, the block spends exactly EXIT_CYC (default 2) cycles in EXITING, with sleep_active=0 and acc_inhibit=1, and then returns to AWAKE with acc_inhibit=0.
- R6: acc_inhibit is 1 in ENTERING, ASLEEP and EXITING, and 0 in AWAKE.
- R7: An acc_start sampled while acc_inhibit is 1 sets recov_viol on the next edge. recov_viol then stays 1 until reset.
- R8: An acc_start sampled in AWAKE leaves recov_viol unchanged.
- R9: acc_busy sampled high on the start-entry edge sets acc_aborted, which stays 1 until reset. acc_busy at any other time has no effect on it.
- R10: If the request falls during ENTERING, entry still completes. The block is ASLEEP for at least one cycle and then exits.
- R11: If the request rises again during EXITING, the exit completes and the block is AWAKE for one cycle. Entry then starts again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sleep_req_async | input | 1 | Sleep request, asynchronous to clk |
| acc_start | input | 1 | An access (select or strobe) starts this cycle |
| acc_busy | input | 1 | An access is currently in flight |
| sleep_active | output | 1 | High while in ASLEEP |
| acc_inhibit | output | 1 | High in all states but AWAKE; blocks or cancels accesses |
| recov_viol | output | 1 | Sticky: access start seen while inhibited |
| acc_aborted | output | 1 | Sticky: access in flight when entry began |

## Verification
The hardest situations to reach from the ports are requests that change while the machine is mid-transition. One case is a request that drops while entry is still counting. The other is a request that rises again inside the recovery window. Because of the synchronizer delay, the input must be timed a known number of edges after the edge that set the state.

The stimulus counts edges from each input change to hit both windows exactly. At those points it checks that:
- entry still finishes, with a single ASLEEP cycle before the wake transition;
- recovery still finishes, with one AWAKE cycle before re-entry.

A behavioural reference model runs beside the design, with the request history kept in a queue. Every output is compared against it on every cycle.

// File: rtl/sleep_pkg.sv
package sleep_pkg;
    typedef enum logic [1:0] {
        ST_AWAKE    = 2'd0,
        ST_ENTERING = 2'd1,
        ST_ASLEEP   = 2'd2,
        ST_EXITING  = 2'd3
    } sleep_state_e;
endpackage

// File: rtl/sleep_sync.sv
module sleep_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '0;
                else        chain <= d_async;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '0;
                else        chain <= {chain[STAGES-2:0], d_async};
            end
        end
    endgenerate

    assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/sleep_fsm.sv
module sleep_fsm
    import sleep_pkg::*;
#(
    parameter int ENTER_CYC = 2,
    parameter int EXIT_CYC  = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         req_s,
    output sleep_state_e state,
    output logic         entry_start,
    output logic         sleep_active,
    output logic         acc_inhibit
);
    localparam int MAXC  = (ENTER_CYC > EXIT_CYC) ? ENTER_CYC : EXIT_CYC;
    localparam int CNT_W = $clog2(MAXC) + 1;

    logic [CNT_W-1:0] cnt;

    // state register with phase counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_AWAKE;
            cnt   <= '0;
        end else begin
            unique case (state)
                ST_AWAKE: begin
                    if (req_s) begin
                        state <= ST_ENTERING;
                        cnt   <= CNT_W'(ENTER_CYC - 1);
                    end
                end
                ST_ENTERING: begin
                    if (cnt == '0) state <= ST_ASLEEP;
                    else           cnt   <= cnt - 1'b1;
                end
                ST_ASLEEP: begin
                    if (!req_s) begin
                        state <= ST_EXITING;
                        cnt   <= CNT_W'(EXIT_CYC - 1);
                    end
                end
                ST_EXITING: begin
                    if (cnt == '0) state <= ST_AWAKE;
                    else           cnt   <= cnt - 1'b1;
                end
                default: state <= ST_AWAKE;
            endcase
        end
    end

    // outputs decoded from state
    always_comb begin
        sleep_active = 1'b0;
        acc_inhibit  = 1'b1;
        entry_start  = 1'b0;
        unique case (state)
            ST_AWAKE: begin
                acc_inhibit = 1'b0;
                entry_start = req_s;
            end
            ST_ENTERING: ;
            ST_ASLEEP:   sleep_active = 1'b1;
            ST_EXITING:  ;
            default:     ;
        endcase
    end

    a_r4_rise_after_entering: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sleep_active) |-> $past(state) == ST_ENTERING);
    a_r5_fall_into_exiting: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sleep_active) |-> acc_inhibit);
    a_r6_sleep_implies_inhibit: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_active |-> acc_inhibit);
    a_r2_inhibit_needs_sync: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(acc_inhibit) |-> $past(req_s));
endmodule

// File: rtl/sleep_flags.sv
module sleep_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic acc_start,
    input  logic acc_busy,
    input  logic inhibit,
    input  logic entry_start,
    output logic viol,
    output logic aborted
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            viol    <= 1'b0;
            aborted <= 1'b0;
        end else begin
            if (acc_start && inhibit)    viol    <= 1'b1;
            if (acc_busy && entry_start) aborted <= 1'b1;
        end
    end

    a_r7_viol_set: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_start && inhibit) |=> viol);
    a_r7_viol_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        viol |=> viol);
    a_r9_abort_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        aborted |=> aborted);
    a_r8_no_viol_when_open: assert property (@(posedge clk) disable iff (!rst_n)
        (!viol && !inhibit) |=> !viol);
endmodule

// File: rtl/sleep_seq.sv
module sleep_seq
    import sleep_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int ENTER_CYC   = 2,
    parameter int EXIT_CYC    = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sleep_req_async,
    input  logic acc_start,
    input  logic acc_busy,
    output logic sleep_active,
    output logic acc_inhibit,
    output logic recov_viol,
    output logic acc_aborted
);
    logic         req_s;
    logic         entry_start;
    sleep_state_e state;

    sleep_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (sleep_req_async),
        .q_sync  (req_s)
    );

    sleep_fsm #(.ENTER_CYC(ENTER_CYC), .EXIT_CYC(EXIT_CYC)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_s        (req_s),
        .state        (state),
        .entry_start  (entry_start),
        .sleep_active (sleep_active),
        .acc_inhibit  (acc_inhibit)
    );

    sleep_flags u_flags (
        .clk         (clk),
        .rst_n       (rst_n),
        .acc_start   (acc_start),
        .acc_busy    (acc_busy),
        .inhibit     (acc_inhibit),
        .entry_start (entry_start),
        .viol        (recov_viol),
        .aborted     (acc_aborted)
    );

    a_r9_abort_on_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_busy && !acc_inhibit && req_s) |=> acc_aborted);
    a_r6_awake_means_open: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_AWAKE) |-> !acc_inhibit);
endmodule

// File: tb/sleep_seq_bench.sv
module sleep_seq_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req = 1'b0;
    logic acc_start = 1'b0;
    logic acc_busy = 1'b0;
    logic sleep_active, acc_inhibit, recov_viol, acc_aborted;

    int total = 0;
    int bad = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    sleep_seq u_sleep_seq (
        .clk             (clk),
        .rst_n           (rst_n),
        .sleep_req_async (req),
        .acc_start       (acc_start),
        .acc_busy        (acc_busy),
        .sleep_active    (sleep_active),
        .acc_inhibit     (acc_inhibit),
        .recov_viol      (recov_viol),
        .acc_aborted     (acc_aborted)
    );

    // behavioural reference model
    bit hist[$];
    int m_st = 0;   // 0 awake, 1 entering, 2 asleep, 3 exiting
    int m_t = 0;
    bit m_viol = 0;
    bit m_abort = 0;

    initial begin
        hist.push_back(1'b0);
        hist.push_back(1'b0);
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            hist.delete();
            hist.push_back(1'b0);
            hist.push_back(1'b0);
            m_st = 0; m_t = 0; m_viol = 0; m_abort = 0;
        end else begin
            bit seen;
            seen = hist.pop_front();
            hist.push_back(req);
            if (m_st != 0 && acc_start) m_viol = 1;
            case (m_st)
                0: if (seen) begin
                       if (acc_busy) m_abort = 1;
                       m_st = 1; m_t = 0;
                   end
                1: begin m_t++; if (m_t == 2) m_st = 2; end
                2: if (!seen) begin m_st = 3; m_t = 0; end
                default: begin m_t++; if (m_t == 2) m_st = 0; end
            endcase
        end
    end

    task automatic chk(string tag, logic act, logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0b expected=%0b at t=%0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            chk("R4 sleep_active vs model", sleep_active, m_st == 2);
            chk("R6 acc_inhibit vs model", acc_inhibit, m_st != 0);
            chk("R7 recov_viol vs model", recov_viol, m_viol);
            chk("R9 acc_aborted vs model", acc_aborted, m_abort);
        end
    end

    task automatic tick(int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #2;
        end
    endtask

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R1 reset state
        chk("R1 inhibit", acc_inhibit, 1'b0);
        chk("R1 sleep", sleep_active, 1'b0);
        chk("R1 viol", recov_viol, 1'b0);
        chk("R1 abort", acc_aborted, 1'b0);

        // R8 access starts while awake, R9 busy with no entry
        acc_start = 1; acc_busy = 1; tick(3); acc_start = 0; acc_busy = 0; tick(1);
        chk("R8 no viol when awake", recov_viol, 1'b0);
        chk("R9 busy alone no abort", acc_aborted, 1'b0);

        // R2/R3 entry timing
        req = 1;
        tick(1); chk("R2 inhibit after 1 edge", acc_inhibit, 1'b0);
        tick(1); chk("R2 inhibit after 2 edges", acc_inhibit, 1'b0);
        tick(1); chk("R2 inhibit after 3 edges", acc_inhibit, 1'b1);
        chk("R3 entering not asleep", sleep_active, 1'b0);
        tick(1); chk("R3 still entering", sleep_active, 1'b0);
        tick(1); chk("R3 asleep after entry", sleep_active, 1'b1);
        tick(4); chk("R4 stays asleep", sleep_active, 1'b1);

        // R5 exit timing
        req = 0;
        tick(2); chk("R5 asleep until sync", sleep_active, 1'b1);
        tick(1); chk("R5 exiting sleep low", sleep_active, 1'b0);
        chk("R5 exiting inhibit", acc_inhibit, 1'b1);
        tick(1); chk("R5 second exit cycle", acc_inhibit, 1'b1);
        tick(1); chk("R5 awake after exit", acc_inhibit, 1'b0);
        tick(3);

        // R10 request dropped during entering
        req = 1; tick(3);
        chk("R10 entering", acc_inhibit, 1'b1);
        req = 0;
        tick(2); chk("R10 entry completes", sleep_active, 1'b1);
        tick(1); chk("R10 exit starts", sleep_active, 1'b0);
        chk("R10 exit inhibited", acc_inhibit, 1'b1);
        tick(4); chk("R10 back awake", acc_inhibit, 1'b0);

        // R11 request re-raised during exiting
        req = 1; tick(8);
        chk("R11 asleep first", sleep_active, 1'b1);
        req = 0; tick(1); req = 1;
        tick(4); chk("R11 awake one cycle", acc_inhibit, 1'b0);
        tick(1); chk("R11 re-entry", acc_inhibit, 1'b1);
        tick(4);

        // R7 access during sleep sets sticky violation
        chk("R7 clean before", recov_viol, 1'b0);
        acc_start = 1; tick(1); acc_start = 0;
        chk("R7 viol set", recov_viol, 1'b1);
        req = 0; tick(8);
        chk("R7 viol sticky when awake", recov_viol, 1'b1);

        // R9 busy at start-entry edge
        acc_busy = 1; req = 1; tick(3);
        chk("R9 abort set", acc_aborted, 1'b1);
        acc_busy = 0; req = 0; tick(10);
        chk("R9 abort sticky", acc_aborted, 1'b1);

        // R1 reset clears sticky flags
        rst_n = 0; tick(2); rst_n = 1; tick(1);
        chk("R1 viol cleared", recov_viol, 1'b0);
        chk("R1 abort cleared", acc_aborted, 1'b0);
        tick(2);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule